// File: doc/BRIEF.md
# Proportional-Integral Loop Filter with Hold and Offset Override

This block is the loop filter of a digital frequency-tracking loop. It takes a signed phase-error sample from an upstream detector and produces a signed frequency control word for a downstream oscillator. The filter has two paths, each scaled by its own programmable power-of-two gain. The proportional path passes the scaled error straight to the output. The integral path adds the scaled error to an accumulator on each filter step. The control word is the sum of the proportional term and the updated accumulator.

The filter does one step on a clock where the load strobe and the filter clock enable are both high. Every intermediate value is clamped to the signed range of the control word. Three sticky-until-next-step flags record clamping at three points: the scaled inputs, the accumulator, and the output sum.

Two overrides sit on top of the filter. A hold input freezes the accumulator and the output register at their last values. An offset-enable input shows an externally supplied signed word on the control output instead of the filter result. While offset is enabled, the filter keeps running in the background. Offset takes priority over hold.

Top module: `pi_loop_filter`

## Requirements
- R1: After synchronous reset, with offset disabled, the control word is 0 and all three saturation flags are 0.
- R2: The proportional gain setting shifts the error left by min(setting, 18), and the integral gain setting shifts it by min(setting, 20). Settings above these maxima act as the maxima.
- R3: On a filter step, the control word seen one clock later is the saturated sum of the proportional term and the updated accumulator.
- R4: On each filter step, the accumulator adds the integral-path term, so its value carries from one step to the next.
- R5: A clock where the load strobe and the filter enable are not both high changes neither the control word nor the flags.
- R6: The input flag (sat_in_o) is 1 after a step in which either scaled term left the signed 22-bit range; that term is clamped to the range limit. The flag returns to 0 after a later step without clamping.
- R7: The accumulator saturates at the signed 22-bit limits, and sat_int_o is 1 after a step in which it clamped.
- R8: The output sum saturates at the signed 22-bit limits (-2097152 to 2097151), and sat_out_o is 1 after a step in which it clamped.
- R9: While offset-enable is high, the control output equals the offset word in the same cycle.
- R10: With hold high and offset-enable low, a filter step changes neither the accumulator nor the output register.
- R11: With hold and offset-enable both high, offset wins: the output shows the offset word, and the filter step still updates the accumulator and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_i | input | 21 | Signed phase-error sample |
| load_i | input | 1 | Error-dump strobe from the detector |
| fce_i | input | 1 | Filter clock enable |
| gain_lin_i | input | 5 | Proportional shift setting, 0 to 18 |
| gain_int_i | input | 5 | Integral shift setting, 0 to 20 |
| hold_i | input | 1 | Freeze the filter state and the output |
| ofs_en_i | input | 1 | Select the offset word for the output |
| ofs_word_i | input | 22 | Signed offset control word |
| ctrl_o | output | 22 | Signed frequency control word |
| sat_in_o | output | 1 | A scaled input term was clamped on the last step |
| sat_int_o | output | 1 | The accumulator was clamped on the last step |
| sat_out_o | output | 1 | The output sum was clamped on the last step |

## Verification
The bench builds the filter with its default parameters: a 21-bit error, a 22-bit control word and shift limits of 18 and 20. With these values, one error sample near full scale shifted by the maximum pushes both scaled terms and the accumulator into clamping within a few steps. The exact negative limit of the output can also be reached without a clamp. Gain codes up to 31 fit in the 5-bit fields, so the clamping of the shift settings is driven directly.

// File: rtl/pi_filt_pkg.sv
package pi_filt_pkg;
    localparam int ERR_W        = 21;
    localparam int CW_W         = 22;
    localparam int GAIN_W       = 5;
    localparam int LIN_GAIN_MAX = 18;
    localparam int INT_GAIN_MAX = 20;

    typedef struct packed {
        logic sat_in;
        logic sat_int;
        logic sat_out;
    } sat_flags_t;
endpackage

// File: rtl/gain_shifter.sv
module gain_shifter #(
    parameter int IN_W   = 21,
    parameter int OUT_W  = 22,
    parameter int SH_W   = 5,
    parameter int MAX_SH = 18
) (
    input  logic signed [IN_W-1:0]  din,
    input  logic        [SH_W-1:0]  sh,
    output logic signed [OUT_W-1:0] dout,
    output logic                    clipped
);
    localparam int WIDE_W = IN_W + MAX_SH + 1;

    logic [SH_W-1:0]          sh_eff;
    logic signed [WIDE_W-1:0] ext;
    logic signed [WIDE_W-1:0] shifted;

    always_comb begin
        sh_eff  = (sh > SH_W'(MAX_SH)) ? SH_W'(MAX_SH) : sh;
        ext     = {{(WIDE_W-IN_W){din[IN_W-1]}}, din};
        shifted = ext <<< sh_eff;
    end

    generate
        if (WIDE_W <= OUT_W) begin : g_no_clip
            always_comb begin
                dout    = {{(OUT_W-WIDE_W){shifted[WIDE_W-1]}}, shifted};
                clipped = 1'b0;
            end
        end else begin : g_clip
            localparam logic signed [WIDE_W-1:0] HI =
                {{(WIDE_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
            localparam logic signed [WIDE_W-1:0] LO =
                {{(WIDE_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
            always_comb begin
                if (shifted > HI) begin
                    dout    = HI[OUT_W-1:0];
                    clipped = 1'b1;
                end else if (shifted < LO) begin
                    dout    = LO[OUT_W-1:0];
                    clipped = 1'b1;
                end else begin
                    dout    = shifted[OUT_W-1:0];
                    clipped = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sat_adder.sv
module sat_adder #(
    parameter int W = 22
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] sum,
    output logic                clipped
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W:0] full;

    always_comb begin
        full    = {a[W-1], a} + {b[W-1], b};
        clipped = full[W] ^ full[W-1];
        if (clipped) begin
            sum = full[W] ? NEG_LIM : POS_LIM;
        end else begin
            sum = full[W-1:0];
        end
    end
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
    import pi_filt_pkg::*;
#(
    parameter int P_ERR_W   = ERR_W,
    parameter int P_CW_W    = CW_W,
    parameter int P_GAIN_W  = GAIN_W,
    parameter int P_LIN_MAX = LIN_GAIN_MAX,
    parameter int P_INT_MAX = INT_GAIN_MAX
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [P_ERR_W-1:0]  err_i,
    input  logic                       load_i,
    input  logic                       fce_i,
    input  logic        [P_GAIN_W-1:0] gain_lin_i,
    input  logic        [P_GAIN_W-1:0] gain_int_i,
    input  logic                       hold_i,
    input  logic                       ofs_en_i,
    input  logic signed [P_CW_W-1:0]   ofs_word_i,
    output logic signed [P_CW_W-1:0]   ctrl_o,
    output logic                       sat_in_o,
    output logic                       sat_int_o,
    output logic                       sat_out_o
);
    logic signed [P_CW_W-1:0] lin_t, int_t, integ_nx, volt_nx;
    logic signed [P_CW_W-1:0] integ_q, volt_q;
    logic                     lin_clip, int_clip, acc_clip, out_clip;
    logic                     run;
    sat_flags_t               flags_q;

    gain_shifter #(.IN_W(P_ERR_W), .OUT_W(P_CW_W), .SH_W(P_GAIN_W), .MAX_SH(P_LIN_MAX))
        u_lin_sh (.din(err_i), .sh(gain_lin_i), .dout(lin_t), .clipped(lin_clip));

    gain_shifter #(.IN_W(P_ERR_W), .OUT_W(P_CW_W), .SH_W(P_GAIN_W), .MAX_SH(P_INT_MAX))
        u_int_sh (.din(err_i), .sh(gain_int_i), .dout(int_t), .clipped(int_clip));

    sat_adder #(.W(P_CW_W))
        u_acc (.a(integ_q), .b(int_t), .sum(integ_nx), .clipped(acc_clip));

    sat_adder #(.W(P_CW_W))
        u_sum (.a(lin_t), .b(integ_nx), .sum(volt_nx), .clipped(out_clip));

    // A filter step needs strobe and enable; hold blocks it unless offset overrides.
    assign run = load_i & fce_i & (~hold_i | ofs_en_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= '0;
            volt_q  <= '0;
            flags_q <= '0;
        end else if (run) begin
            integ_q         <= integ_nx;
            volt_q          <= volt_nx;
            flags_q.sat_in  <= lin_clip | int_clip;
            flags_q.sat_int <= acc_clip;
            flags_q.sat_out <= out_clip;
        end
    end

    assign ctrl_o    = ofs_en_i ? ofs_word_i : volt_q;
    assign sat_in_o  = flags_q.sat_in;
    assign sat_int_o = flags_q.sat_int;
    assign sat_out_o = flags_q.sat_out;
endmodule

// File: rtl/pi_filt_chk.sv
module pi_filt_chk #(
    parameter int CW = 22
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 load_i,
    input logic                 fce_i,
    input logic                 hold_i,
    input logic                 ofs_en_i,
    input logic signed [CW-1:0] integ_q,
    input logic signed [CW-1:0] volt_q,
    input logic                 sat_in_o,
    input logic                 sat_int_o,
    input logic                 sat_out_o
);
    localparam logic signed [CW-1:0] TOP = {1'b0, {(CW-1){1'b1}}};
    localparam logic signed [CW-1:0] BOT = {1'b1, {(CW-1){1'b0}}};

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(load_i && fce_i) |=> $stable(volt_q) && $stable(integ_q)) else $error("idle"); // R5
    AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !(load_i && fce_i) |=> $stable({sat_in_o, sat_int_o, sat_out_o})) else $error("flags"); // R5
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (load_i && fce_i && hold_i && !ofs_en_i) |=> $stable(volt_q) && $stable(integ_q)) else $error("hold"); // R10
    AST_INT_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        sat_int_o |-> (integ_q == TOP || integ_q == BOT)) else $error("int lim"); // R7
    AST_OUT_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        sat_out_o |-> (volt_q == TOP || volt_q == BOT)) else $error("out lim"); // R8
endmodule

bind pi_loop_filter pi_filt_chk #(.CW(P_CW_W)) u_chk (
    .clk(clk), .rst(rst), .load_i(load_i), .fce_i(fce_i), .hold_i(hold_i),
    .ofs_en_i(ofs_en_i), .integ_q(integ_q), .volt_q(volt_q),
    .sat_in_o(sat_in_o), .sat_int_o(sat_int_o), .sat_out_o(sat_out_o)
);

// File: tb/pi_loop_filter_bench.sv
module pi_loop_filter_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst;
    logic signed [20:0] err_i;
    logic               load_i, fce_i, hold_i, ofs_en_i;
    logic        [4:0]  gain_lin_i, gain_int_i;
    logic signed [21:0] ofs_word_i;
    logic signed [21:0] ctrl_o;
    logic               sat_in_o, sat_int_o, sat_out_o;

    pi_loop_filter u_pi_loop_filter (
        .clk(clk), .rst(rst), .err_i(err_i), .load_i(load_i), .fce_i(fce_i),
        .gain_lin_i(gain_lin_i), .gain_int_i(gain_int_i), .hold_i(hold_i),
        .ofs_en_i(ofs_en_i), .ofs_word_i(ofs_word_i), .ctrl_o(ctrl_o),
        .sat_in_o(sat_in_o), .sat_int_o(sat_int_o), .sat_out_o(sat_out_o)
    );

    typedef struct {
        longint ctrl;
        bit [2:0] fl;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;

    localparam longint LIM_HI = 2097151;
    localparam longint LIM_LO = -2097152;

    longint m_int = 0;
    longint m_volt = 0;
    bit [2:0] m_fl = 3'b000;

    function automatic longint clampv(longint v, output bit c);
        c = 1'b0;
        if (v > LIM_HI) begin c = 1'b1; return LIM_HI; end
        if (v < LIM_LO) begin c = 1'b1; return LIM_LO; end
        return v;
    endfunction

    task automatic drive(bit ld, bit fe, bit hd, bit oe, longint ofs,
                         longint err, int g1, int g2, string tag);
        exp_t e;
        longint l, i;
        bit c1, c2, c3, c4;
        @(negedge clk);
        load_i = ld; fce_i = fe; hold_i = hd; ofs_en_i = oe;
        ofs_word_i = 22'(ofs); err_i = 21'(err);
        gain_lin_i = 5'(g1); gain_int_i = 5'(g2);
        if (ld && fe && (!hd || oe)) begin
            l = clampv(err <<< ((g1 > 18) ? 18 : g1), c1);
            i = clampv(err <<< ((g2 > 20) ? 20 : g2), c2);
            m_int  = clampv(m_int + i, c3);
            m_volt = clampv(l + m_int, c4);
            m_fl   = {c1 | c2, c3, c4};
        end
        e.ctrl = oe ? ofs : m_volt;
        e.fl   = m_fl;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (longint'(ctrl_o) != e.ctrl || {sat_in_o, sat_int_o, sat_out_o} != e.fl) begin
                failures++;
                $display("FAIL %s: ctrl=%0d flags=%b expected ctrl=%0d flags=%b",
                         e.tag, ctrl_o, {sat_in_o, sat_int_o, sat_out_o}, e.ctrl, e.fl);
            end
        end
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; err_i = '0; load_i = 0; fce_i = 0; hold_i = 0; ofs_en_i = 0;
        ofs_word_i = '0; gain_lin_i = '0; gain_int_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++; // R1 reset state
        if (ctrl_o != 0 || {sat_in_o, sat_int_o, sat_out_o} != 3'b000) begin
            failures++;
            $display("FAIL R1: ctrl=%0d flags=%b expected ctrl=0 flags=000",
                     ctrl_o, {sat_in_o, sat_int_o, sat_out_o});
        end
        drive(1, 1, 0, 0, 0, 100, 2, 0, "R3");
        drive(1, 1, 0, 0, 0, 100, 2, 0, "R4");
        drive(1, 0, 0, 0, 0, 5000, 3, 3, "R5");
        drive(0, 1, 0, 0, 0, 5000, 3, 3, "R5");
        drive(1, 1, 0, 0, 0, -300, 1, 1, "R4");
        drive(1, 1, 0, 0, 0, 1, 31, 0, "R2");
        drive(1, 1, 0, 0, 0, 1, 0, 31, "R2");
        drive(1, 1, 0, 0, 0, 1000, 18, 0, "R6");
        drive(1, 1, 0, 0, 0, 1048575, 0, 20, "R7");
        drive(1, 1, 0, 0, 0, -1048576, 1, 0, "R8");
        drive(1, 1, 0, 0, 0, -1048576, 18, 0, "R8");
        drive(1, 1, 0, 0, 0, 3, 2, 0, "R6");
        drive(1, 1, 1, 0, 0, 500, 4, 4, "R10");
        drive(0, 0, 1, 0, 0, 0, 0, 0, "R10");
        drive(0, 0, 0, 1, -12345, 0, 0, 0, "R9");
        drive(0, 0, 0, 1, 2097151, 0, 0, 0, "R9");
        drive(1, 1, 1, 1, 777, 10, 0, 0, "R11");
        drive(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        drive(1, 1, 0, 0, 0, -7, 0, 3, "R3");
        drive(0, 0, 0, 0, 0, 0, 0, 0, "R5");
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule